// File: doc/BRIEF.md
# Eight-Way Streaming Merge Tree

This block merges eight key-value streams, each already sorted by key, into a single sorted stream. Each input has its own small buffer and a valid/ready handshake. A run on an input is closed by a terminator beat, which carries no pair. Seven two-input selector nodes form a three-level binary tree. Each node holds a two-entry output buffer, so a stall at the output moves back through the tree one level per cycle and no pair is lost or duplicated.

Keys are compared as plain unsigned integers. The only goal is that equal keys come out adjacent, so keys of any meaning can be sorted this way. The output raises a last flag on the final pair of a pass. The tree then takes the next set of runs without a reset, so a memory-side controller can drive repeated passes. Each pass makes runs eight times longer, which gives a full sort in ceil(log8 N) passes.

Top module: `mtree_top`

## Requirements
- R1: Each input accepts beats while its buffer of BUF_DEPTH entries has room. After reset every `in_ready` bit is 1 and `out_valid` is 0.
- R2: Within one pass, the keys that leave the output never decrease when read as unsigned numbers. A key with bit 31 set ranks above every key with bit 31 clear.
- R3: Every pair offered on any input leaves the output exactly once, with its value unchanged and still paired with its own key.
- R4: When keys are equal, the pair from the lower-numbered input leaves first. Pairs from the same input keep their arrival order.
- R5: A beat with `in_end` = 1 carries no pair and closes that input's run. An input with a closed run never wins a comparison. A run may hold zero pairs.
- R6: `out_last` is 1 together with the final pair of a pass, and only with that pair. A pass in which all eight runs are empty produces no output beat. The next pass then merges normally.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` = 1 with the same key and value.
- R8: Suppose every input is fed one beat per cycle without gaps and `out_ready` stays 1. Then the N pairs of a pass leave within N+1 cycles, counted from the cycle of the first pair to the cycle of the last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 8 | Beat offered on input j (bit j) |
| in_ready | output | 8 | Input j's buffer has room |
| in_end | input | 8 | Offered beat on input j is a run terminator |
| in_key | input | 8*KEY_W | Key of input j in bits [j*KEY_W +: KEY_W] |
| in_val | input | 8*VAL_W | Value of input j in bits [j*VAL_W +: VAL_W] |
| out_valid | output | 1 | Merged pair present |
| out_ready | input | 1 | Consumer takes the pair |
| out_key | output | KEY_W | Merged key |
| out_val | output | VAL_W | Value travelling with out_key |
| out_last | output | 1 | Pair is the last of the pass |

## Verification
A node that picks the wrong child appears at the output within about four cycles. It shows up either as a key lower than the one before it, or as equal keys whose values carry the wrong input tag. A buffer that drops or repeats an entry shows up as a missing or extra value against the scoreboard. Such an error usually happens under output stalls, and it is reported by the end of that pass. A terminator that is handled badly shows up as a hung pass, as a misplaced `out_last`, or as data from the next pass slipping into the current one.

// File: rtl/mtree_pkg.sv
package mtree_pkg;
    localparam int WAYS   = 8;
    localparam int LEVELS = $clog2(WAYS);
    localparam int NODES  = WAYS - 1;
    localparam int SLOTS  = NODES + WAYS;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_LEFT  = 2'd1,
        SEL_RIGHT = 2'd2,
        SEL_BOTH  = 2'd3
    } sel_e;

    // Decide which child advances; a closed child never wins, ties go left.
    function automatic sel_e choose(logic l_fin, logic r_fin, logic l_le_r);
        if (l_fin && r_fin)
            return SEL_BOTH;
        else if (r_fin || (!l_fin && l_le_r))
            return SEL_LEFT;
        else
            return SEL_RIGHT;
    endfunction
endpackage

// File: rtl/mtree_fifo.sv
module mtree_fifo #(
    parameter int W     = 65,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_valid,
    output logic         wr_ready,
    input  logic [W-1:0] wr_data,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    input  logic         rd_take
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push, pop;

    assign wr_ready = (cnt != CW'(DEPTH));
    assign rd_valid = (cnt != '0);
    assign rd_data  = mem[rp];
    assign push     = wr_valid & wr_ready;
    assign pop      = rd_take & rd_valid;

    always_ff @(posedge clk) begin
        if (push)
            mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push)
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    // R1
    take_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        rd_take |-> cnt != '0);

    // R1
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/mtree_node.sv
module mtree_node
    import mtree_pkg::*;
#(
    parameter int KEY_W = 32,
    parameter int VAL_W = 32,
    parameter bit PASS  = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             l_valid,
    input  logic             l_end,
    input  logic [KEY_W-1:0] l_key,
    input  logic [VAL_W-1:0] l_val,
    output logic             l_take,
    input  logic             r_valid,
    input  logic             r_end,
    input  logic [KEY_W-1:0] r_key,
    input  logic [VAL_W-1:0] r_val,
    output logic             r_take,
    output logic             o_valid,
    output logic             o_end,
    output logic [KEY_W-1:0] o_key,
    output logic [VAL_W-1:0] o_val,
    output logic             o_nvalid,
    output logic             o_nend,
    input  logic             o_take
);
    localparam int EW = 1 + KEY_W + VAL_W;

    logic [EW-1:0] e0, e1, ent_new;
    logic [1:0]    cnt;
    logic          room, push, pop;
    sel_e          sel;

    assign pop  = o_take & (cnt != 2'd0);
    assign room = (cnt != 2'd2) | (PASS & pop);

    always_comb begin
        if (l_valid && r_valid && room)
            sel = choose(l_end, r_end, l_key <= r_key);
        else
            sel = SEL_NONE;
    end

    assign push   = (sel != SEL_NONE);
    assign l_take = (sel == SEL_LEFT)  || (sel == SEL_BOTH);
    assign r_take = (sel == SEL_RIGHT) || (sel == SEL_BOTH);

    always_comb begin
        if (sel == SEL_RIGHT)
            ent_new = {1'b0, r_key, r_val};
        else
            ent_new = {sel == SEL_BOTH, l_key, l_val};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= 2'd0;
            e0  <= '0;
            e1  <= '0;
        end else begin
            case ({push, pop})
                2'b10: begin
                    if (cnt == 2'd0) e0 <= ent_new;
                    else             e1 <= ent_new;
                    cnt <= cnt + 2'd1;
                end
                2'b01: begin
                    e0  <= e1;
                    cnt <= cnt - 2'd1;
                end
                2'b11: begin
                    if (cnt == 2'd1) begin
                        e0 <= ent_new;
                    end else begin
                        e0 <= e1;
                        e1 <= ent_new;
                    end
                end
                default: ;
            endcase
        end
    end

    assign o_valid  = (cnt != 2'd0);
    assign o_end    = e0[EW-1];
    assign o_key    = e0[VAL_W +: KEY_W];
    assign o_val    = e0[VAL_W-1:0];
    assign o_nvalid = (cnt == 2'd2);
    assign o_nend   = e1[EW-1];

    // Checker state: last key pushed in the current run.
    logic             seen_q;
    logic [KEY_W-1:0] prev_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            prev_q <= '0;
        end else if (push) begin
            seen_q <= ~ent_new[EW-1];
            prev_q <= ent_new[VAL_W +: KEY_W];
        end
    end

    // R2
    run_order_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !ent_new[EW-1] && seen_q) |-> ent_new[VAL_W +: KEY_W] >= prev_q);

    // R5
    end_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (l_take && l_end) |-> (r_take && r_end));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt != 2'd3);
endmodule

// File: rtl/mtree_top.sv
module mtree_top
    import mtree_pkg::*;
#(
    parameter int KEY_W     = 32,
    parameter int VAL_W     = 32,
    parameter int BUF_DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WAYS-1:0]        in_valid,
    output logic [WAYS-1:0]        in_ready,
    input  logic [WAYS-1:0]        in_end,
    input  logic [WAYS*KEY_W-1:0]  in_key,
    input  logic [WAYS*VAL_W-1:0]  in_val,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [KEY_W-1:0]       out_key,
    output logic [VAL_W-1:0]       out_val,
    output logic                   out_last
);
    localparam int EW = 1 + KEY_W + VAL_W;

    // Heap layout: slot 0 is the root, slot i feeds from 2i+1 and 2i+2,
    // slots NODES..SLOTS-1 are the input buffers in input order.
    logic             s_valid [SLOTS];
    logic             s_end   [SLOTS];
    logic [KEY_W-1:0] s_key   [SLOTS];
    logic [VAL_W-1:0] s_val   [SLOTS];
    logic             s_take  [SLOTS];
    logic             s_nvalid [NODES];
    logic             s_nend   [NODES];

    for (genvar j = 0; j < WAYS; j++) begin : g_leaf
        logic [EW-1:0] rd_word;
        mtree_fifo #(.W(EW), .DEPTH(BUF_DEPTH)) u_buf (
            .clk      (clk),
            .rst      (rst),
            .wr_valid (in_valid[j]),
            .wr_ready (in_ready[j]),
            .wr_data  ({in_end[j], in_key[j*KEY_W +: KEY_W], in_val[j*VAL_W +: VAL_W]}),
            .rd_valid (s_valid[NODES+j]),
            .rd_data  (rd_word),
            .rd_take  (s_take[NODES+j])
        );
        assign s_end[NODES+j] = rd_word[EW-1];
        assign s_key[NODES+j] = rd_word[VAL_W +: KEY_W];
        assign s_val[NODES+j] = rd_word[VAL_W-1:0];
    end

    for (genvar i = 0; i < NODES; i++) begin : g_node
        mtree_node #(.KEY_W(KEY_W), .VAL_W(VAL_W), .PASS(i == 0)) u_node (
            .clk      (clk),
            .rst      (rst),
            .l_valid  (s_valid[2*i+1]),
            .l_end    (s_end[2*i+1]),
            .l_key    (s_key[2*i+1]),
            .l_val    (s_val[2*i+1]),
            .l_take   (s_take[2*i+1]),
            .r_valid  (s_valid[2*i+2]),
            .r_end    (s_end[2*i+2]),
            .r_key    (s_key[2*i+2]),
            .r_val    (s_val[2*i+2]),
            .r_take   (s_take[2*i+2]),
            .o_valid  (s_valid[i]),
            .o_end    (s_end[i]),
            .o_key    (s_key[i]),
            .o_val    (s_val[i]),
            .o_nvalid (s_nvalid[i]),
            .o_nend   (s_nend[i]),
            .o_take   (s_take[i])
        );
    end

    // A data head is shown only once its successor is known, so the
    // final pair can carry the last flag; a terminator head is dropped.
    assign out_valid = s_valid[0] & ~s_end[0] & s_nvalid[0];
    assign out_last  = s_nend[0];
    assign out_key   = s_key[0];
    assign out_val   = s_val[0];
    assign s_take[0] = (out_valid & out_ready) | (s_valid[0] & s_end[0]);

    logic             o_seen_q;
    logic [KEY_W-1:0] o_prev_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            o_seen_q <= 1'b0;
            o_prev_q <= '0;
        end else if (out_valid && out_ready) begin
            o_seen_q <= ~out_last;
            o_prev_q <= out_key;
        end
    end

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_key) && $stable(out_val)));

    // R2
    out_order_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && o_seen_q) |-> out_key >= o_prev_q);

    // R6
    last_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

// File: tb/mtree_top_bench.sv
module mtree_top_bench;
    localparam int KW = 32;
    localparam int VW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    in_valid = '0;
    logic [7:0]    in_ready;
    logic [7:0]    in_end = '0;
    logic [8*KW-1:0] in_key = '0;
    logic [8*VW-1:0] in_val = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [KW-1:0] out_key;
    logic [VW-1:0] out_val;
    logic          out_last;

    mtree_top #(.KEY_W(KW), .VAL_W(VW), .BUF_DEPTH(4)) u_mtree_top (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_end(in_end),
        .in_key(in_key), .in_val(in_val),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_key(out_key), .out_val(out_val), .out_last(out_last)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [31:0] src_k [8][$];
    logic [31:0] src_v [8][$];
    logic [31:0] exp_k [$];
    logic [31:0] exp_v [$];
    int first_c, last_c;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_bad);
            $finish;
        end
    end

    task automatic check(bit ok, string req, string what);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    // kind 0: small steps with ties, 1: mix around bit 31, 2: one shared key
    task automatic make_runs(int lens[8], int kind);
        exp_k.delete();
        exp_v.delete();
        for (int j = 0; j < 8; j++) begin
            logic [31:0] k;
            src_k[j].delete();
            src_v[j].delete();
            k = (kind == 1) ? 32'h7FFF_FFF0 + ($urandom % 8) : ($urandom % 6);
            for (int i = 0; i < lens[j]; i++) begin
                if (kind == 1)      k = k + (($urandom % 3 == 0) ? 32'h1000_0000 : ($urandom % 3));
                else if (kind == 2) k = 32'd77;
                else                k = k + ($urandom % 3);
                src_k[j].push_back(k);
                src_v[j].push_back({4'(j), 28'(i)} ^ 32'hA500_0000);
            end
        end
        // stable order: key, then input number, then arrival
        for (int j = 0; j < 8; j++) begin
            for (int i = 0; i < lens[j]; i++) begin
                int pos = exp_k.size();
                for (int p = 0; p < exp_k.size(); p++) begin
                    if (exp_k[p] > src_k[j][i]) begin
                        pos = p;
                        break;
                    end
                end
                exp_k.insert(pos, src_k[j][i]);
                exp_v.insert(pos, src_v[j][i]);
            end
        end
    endtask

    task automatic drive_stream(int j, bit stall);
        int n = src_k[j].size();
        for (int i = 0; i <= n; i++) begin
            bit done = 1'b0;
            while (!done) begin
                @(negedge clk);
                if (stall && ($urandom % 4 == 0)) begin
                    in_valid[j] = 1'b0;
                end else begin
                    in_valid[j] = 1'b1;
                    in_end[j]   = (i == n);
                    in_key[j*KW +: KW] = (i < n) ? src_k[j][i] : 32'hDEAD_0000;
                    in_val[j*VW +: VW] = (i < n) ? src_v[j][i] : 32'hDEAD_FFFF;
                    done = in_ready[j];
                end
            end
        end
        @(negedge clk);
        in_valid[j] = 1'b0;
        in_end[j]   = 1'b0;
    endtask

    task automatic monitor(bit stall);
        bit held = 1'b0;
        logic [31:0] hk = '0, hv = '0;
        bit first = 1'b1;
        while (exp_k.size() > 0) begin
            @(negedge clk);
            out_ready = stall ? ($urandom % 3 != 0) : 1'b1;
            #1;
            if (held)
                check(out_valid && out_key == hk && out_val == hv, "R7",
                      $sformatf("held pair changed: actual v=%0d k=%h val=%h expected k=%h val=%h",
                                out_valid, out_key, out_val, hk, hv));
            if (out_valid && out_ready) begin
                logic [31:0] ek = exp_k.pop_front();
                logic [31:0] ev = exp_v.pop_front();
                bit el = (exp_k.size() == 0);
                if (first) first_c = cyc;
                first = 1'b0;
                last_c = cyc;
                check(out_key == ek, "R2", $sformatf("key actual %h expected %h", out_key, ek));
                check(out_val == ev, "R3/R4", $sformatf("value actual %h expected %h", out_val, ev));
                check(out_last == el, "R6", $sformatf("last actual %0d expected %0d", out_last, el));
            end
            held = out_valid && !out_ready;
            hk = out_key;
            hv = out_val;
        end
        @(negedge clk);
        out_ready = 1'b1;
    endtask

    task automatic run_pass(int lens[8], int kind, bit stall, string tag);
        make_runs(lens, kind);
        fork
            drive_stream(0, stall);
            drive_stream(1, stall);
            drive_stream(2, stall);
            drive_stream(3, stall);
            drive_stream(4, stall);
            drive_stream(5, stall);
            drive_stream(6, stall);
            drive_stream(7, stall);
            monitor(stall);
        join
        // nothing extra may follow the pass (R3: no duplicates)
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            out_ready = 1'b1;
            #1;
            check(!out_valid, "R3", $sformatf("%s: extra beat actual valid=%0d key=%h expected none",
                                               tag, out_valid, out_key));
        end
    endtask

    initial begin
        int l_mix[8]   = '{7, 12, 3, 9, 15, 1, 6, 10};
        int l_empty[8] = '{0, 8, 5, 0, 11, 4, 2, 0};
        int l_none[8]  = '{0, 0, 0, 0, 0, 0, 0, 0};
        int l_flat[8]  = '{10, 10, 10, 10, 10, 10, 10, 10};
        int l_tie[8]   = '{3, 2, 4, 1, 3, 2, 1, 3};
        int total;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: reset state
        check(in_ready == 8'hFF, "R1", $sformatf("in_ready actual %h expected ff", in_ready));
        check(!out_valid, "R1", $sformatf("out_valid actual %0d expected 0", out_valid));

        // R2 R3 R4 R6 R7: random stalls on both sides
        run_pass(l_mix, 0, 1'b1, "mixed");
        // R5: empty runs among full ones
        run_pass(l_empty, 0, 1'b1, "empty runs");
        // R6: a pass with no pairs at all, then normal merging again
        run_pass(l_none, 0, 1'b1, "all empty");
        // R2: unsigned ranking across bit 31
        run_pass(l_mix, 1, 1'b1, "wide keys");
        // R4: all keys equal, order set by input number
        run_pass(l_tie, 2, 1'b1, "ties");

        // R8: gap-free throughput
        total = 0;
        for (int j = 0; j < 8; j++) total += l_flat[j];
        run_pass(l_flat, 0, 1'b0, "throughput");
        check(last_c - first_c <= total, "R8",
              $sformatf("span actual %0d cycles expected at most %0d", last_c - first_c, total));

        // R1: buffer room fills when nothing is drained at the tree root
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 8'h01;
        in_end   = 8'h00;
        in_key[31:0] = 32'd5;
        repeat (8) @(negedge clk);
        #1;
        check(in_ready[0] == 1'b0, "R1", $sformatf("in_ready[0] actual %0d expected 0 when full", in_ready[0]));
        check(in_ready[7:1] == 7'h7F, "R1", $sformatf("other in_ready actual %h expected 7f", in_ready[7:1]));
        check(!out_valid, "R5", $sformatf("out_valid actual %0d expected 0 while other runs open", out_valid));
        in_valid = '0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule